// File: doc/BRIEF.md
# Mailbox Command Requester Sequencer

This block runs one command against a device-side mailbox through a simple memory-mapped read/write master, on behalf of a local client. The client supplies an opcode, an input length, an output capacity and a start pulse. The sequencer checks that the mailbox is free and writes the command word. It then rings the doorbell and waits for the device to drop it. It reads the return code, and follows a long-running background command to completion when the device asks it to. The payload itself is not moved: the data path is reduced to lengths. The command word carries the input length, and the client gets back a clamped output length.

Each bus access holds its request, address, direction and write data steady until the responder acknowledges it. Only one access is outstanding at a time. The client sees a one-cycle done pulse. The error status, return code and output length stay valid until the next start.

Top module: `mbx_req_seq`

## Requirements
- R1: A start with a nonzero input length and `in_buf_i` low finishes with error 3 (invalid) and makes no bus access at all.
- R2: The first bus access of every accepted start is a read of the control register (offset 0x04). If its bit 0 (doorbell) is set, the command finishes with error 1 (busy) and no write is issued.
- R3: While `long_pend_i` is high, any opcode other than `HEALTH_OPC` (default 0x4200) finishes with error 1 (busy) and no write is issued. The health opcode proceeds normally.
- R4: The command register (offset 0x08) is written with the opcode in bits [15:0] and the input length in bits [36:16], which is zero for a zero length. Only after that write is the control register written with bit 0 set. Every request is held with a stable address until it is acknowledged.
- R5: After the doorbell write, the control register is polled until bit 0 reads clear. Once `DB_TMO` cycles of polling have passed with the bit still set, one further control read is made. The command finishes with error 2 (timeout) only if that read still shows the bit set. Otherwise it continues normally.
- R6: Once the doorbell clears, the status register (offset 0x10) is read and its return code is taken from bits [47:32]. Any code other than success (0) or background (`RC_BG`, default 1) finishes with error 0, that code on `rc_o`, an output length of 0, and no read-back of the command register.
- R7: A background return code starts polling of the background status register (offset 0x18). Completion means its bits [22:16] equal 100. There are max(`poll_cnt_i`,1) reads at most, and a wait of `poll_ivl_i` cycles comes before each one when the count is nonzero. If the last read is still incomplete, the command finishes with error 2.
- R8: On background completion, the final return code comes from bits [47:32] of the background status register. A non-success value there ends the command as in R6.
- R9: On success, the command register is read back. `out_len_o` is the minimum of `out_cap_i`, `pld_size_i` and the returned length field [36:16]. It is 0 when `out_buf_i` is low.
- R10: `done_o` is high for exactly one cycle per command. `err_o`, `rc_o` and `out_len_o` hold their values until the next start.
- R11: After reset, `busy_o`, `done_o`, `bus_req_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| opcode_i | input | 16 | Command opcode |
| in_len_i | input | 21 | Input payload length in bytes |
| in_buf_i | input | 1 | Input buffer present |
| out_cap_i | input | 21 | Client output capacity in bytes |
| out_buf_i | input | 1 | Output buffer present |
| pld_size_i | input | 21 | Device payload size in bytes |
| long_pend_i | input | 1 | A long exclusive operation is pending |
| poll_cnt_i | input | PCNT_W | Maximum background poll intervals |
| poll_ivl_i | input | IVL_W | Background poll interval in cycles |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 0 none, 1 busy, 2 timeout, 3 invalid |
| rc_o | output | 16 | Device return code |
| out_len_o | output | 21 | Clamped output length |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Bus write when high |
| bus_addr_o | output | 8 | Register offset |
| bus_wdata_o | output | 64 | Write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | 64 | Read data, valid with acknowledge |

## Verification
The hardest case to reach is the final re-check after the doorbell timeout. Here the device clears the doorbell exactly on the extra read that follows an expired poll window, so the command must still succeed. The bench cannot time this from the timeout value alone, because the number of poll reads depends on the bus latency. It therefore first runs a command whose doorbell never clears, counts the control reads made after the ring, and then runs the same command with the responder set to clear the doorbell on that last counted read. Background polling is driven the same way, by choosing which background-status read first reports 100 percent.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned OPC_W   = 16;
  localparam int unsigned LEN_W   = 21;
  localparam int unsigned RC_W    = 16;
  localparam int unsigned PCT_W   = 7;

  localparam int unsigned DB_BIT  = 0;
  localparam int unsigned LEN_LSB = 16;
  localparam int unsigned RC_LSB  = 32;
  localparam int unsigned PCT_LSB = 16;
  localparam logic [PCT_W-1:0] PCT_DONE = 7'd100;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] A_CMD  = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] A_BG   = 8'h18;

  typedef enum logic [1:0] {
    E_NONE  = 2'd0,
    E_BUSY  = 2'd1,
    E_TMO   = 2'd2,
    E_INVAL = 2'd3
  } mbx_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTRL, S_WR_CMD, S_WR_DB, S_POLL_DB, S_RECHK,
    S_RD_STAT, S_BG_WAIT, S_BG_RD, S_RD_LEN, S_DONE
  } mbx_st_e;
endpackage

// File: rtl/mbx_tick_cnt.sv
module mbx_tick_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q >= limit_i);

  // R5
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mbx_len_clamp.sv
module mbx_len_clamp #(
  parameter int unsigned W = 21,
  parameter int unsigned N = 3
) (
  input  logic [N-1:0][W-1:0] vals_i,
  output logic [W-1:0]        min_o
);
  logic [W-1:0] chain [N];

  assign chain[0] = vals_i[0];
  for (genvar g = 1; g < N; g++) begin : g_min
    assign chain[g] = (vals_i[g] < chain[g-1]) ? vals_i[g] : chain[g-1];
  end
  assign min_o = chain[N-1];
endmodule

// File: rtl/mbx_req_seq.sv
module mbx_req_seq
  import mbx_pkg::*;
#(
  parameter int unsigned     DB_TMO     = 1000,
  parameter int unsigned     PCNT_W     = 8,
  parameter int unsigned     IVL_W      = 16,
  parameter logic [15:0]     HEALTH_OPC = 16'h4200,
  parameter logic [15:0]     RC_OK      = 16'h0000,
  parameter logic [15:0]     RC_BG      = 16'h0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       opcode_i,
  input  logic [20:0]       in_len_i,
  input  logic              in_buf_i,
  input  logic [20:0]       out_cap_i,
  input  logic              out_buf_i,
  input  logic [20:0]       pld_size_i,
  input  logic              long_pend_i,
  input  logic [PCNT_W-1:0] poll_cnt_i,
  input  logic [IVL_W-1:0]  poll_ivl_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [15:0]       rc_o,
  output logic [20:0]       out_len_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [7:0]        bus_addr_o,
  output logic [63:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [63:0]       bus_rdata_i
);
  localparam int unsigned TW = $clog2(DB_TMO + 1);
  localparam int unsigned IW = PCNT_W + 1;
  localparam logic [TW-1:0] DB_LIMIT = TW'(DB_TMO);

  mbx_st_e          st_q;
  mbx_err_e         err_q;
  logic [OPC_W-1:0] opc_q;
  logic [LEN_W-1:0] len_q, cap_q, psz_q, olen_q;
  logic             obuf_q;
  logic [PCNT_W-1:0] cnt_q;
  logic [IVL_W-1:0] ivl_q;
  logic [IW-1:0]    iv_q, iv_nxt;
  logic [RC_W-1:0]  rc_q;
  logic             cmd_wr_seen;

  logic             db_hit, ivl_hit;
  logic             rd_db;
  logic [RC_W-1:0]  rd_rc;
  logic [LEN_W-1:0] rd_len, clamp_len;
  logic [PCT_W-1:0] rd_pct;
  logic             unused_rdata;

  assign rd_db  = bus_rdata_i[DB_BIT];
  assign rd_rc  = bus_rdata_i[RC_LSB +: RC_W];
  assign rd_len = bus_rdata_i[LEN_LSB +: LEN_W];
  assign rd_pct = bus_rdata_i[PCT_LSB +: PCT_W];
  assign unused_rdata = ^bus_rdata_i;
  assign iv_nxt = iv_q + 1'b1;

  mbx_tick_cnt #(.W(TW)) u_db_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != S_POLL_DB && st_q != S_RECHK),
    .en_i    (st_q == S_POLL_DB),
    .limit_i (DB_LIMIT),
    .hit_o   (db_hit)
  );

  mbx_tick_cnt #(.W(IVL_W)) u_ivl_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != S_BG_WAIT),
    .en_i    (st_q == S_BG_WAIT),
    .limit_i (ivl_q),
    .hit_o   (ivl_hit)
  );

  mbx_len_clamp #(.W(LEN_W), .N(3)) u_clamp (
    .vals_i ({rd_len, psz_q, cap_q}),
    .min_o  (clamp_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      err_q  <= E_NONE;
      rc_q   <= '0;
      olen_q <= '0;
      opc_q  <= '0;
      len_q  <= '0;
      cap_q  <= '0;
      psz_q  <= '0;
      obuf_q <= 1'b0;
      cnt_q  <= '0;
      ivl_q  <= '0;
      iv_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          opc_q  <= opcode_i;
          len_q  <= in_len_i;
          cap_q  <= out_cap_i;
          psz_q  <= pld_size_i;
          obuf_q <= out_buf_i;
          cnt_q  <= poll_cnt_i;
          ivl_q  <= poll_ivl_i;
          err_q  <= E_NONE;
          rc_q   <= '0;
          olen_q <= '0;
          if (in_len_i != '0 && !in_buf_i) begin
            err_q <= E_INVAL;
            st_q  <= S_DONE;
          end else begin
            st_q  <= S_RD_CTRL;
          end
        end
        S_RD_CTRL: if (bus_ack_i) begin
          if (rd_db || (long_pend_i && opc_q != HEALTH_OPC)) begin
            err_q <= E_BUSY;
            st_q  <= S_DONE;
          end else begin
            st_q  <= S_WR_CMD;
          end
        end
        S_WR_CMD: if (bus_ack_i) st_q <= S_WR_DB;
        S_WR_DB:  if (bus_ack_i) st_q <= S_POLL_DB;
        S_POLL_DB: if (bus_ack_i) begin
          if (!rd_db)      st_q <= S_RD_STAT;
          else if (db_hit) st_q <= S_RECHK;
        end
        S_RECHK: if (bus_ack_i) begin
          if (!rd_db) st_q <= S_RD_STAT;
          else begin
            err_q <= E_TMO;
            st_q  <= S_DONE;
          end
        end
        S_RD_STAT: if (bus_ack_i) begin
          rc_q <= rd_rc;
          if (rd_rc == RC_BG) begin
            iv_q <= '0;
            st_q <= (cnt_q == '0) ? S_BG_RD : S_BG_WAIT;
          end else if (rd_rc != RC_OK) begin
            st_q <= S_DONE;
          end else begin
            st_q <= S_RD_LEN;
          end
        end
        S_BG_WAIT: if (ivl_hit) st_q <= S_BG_RD;
        S_BG_RD: if (bus_ack_i) begin
          if (rd_pct == PCT_DONE) begin
            rc_q <= rd_rc;
            st_q <= (rd_rc != RC_OK) ? S_DONE : S_RD_LEN;
          end else begin
            iv_q <= iv_nxt;
            if (iv_nxt >= {1'b0, cnt_q}) begin
              err_q <= E_TMO;
              st_q  <= S_DONE;
            end else begin
              st_q  <= S_BG_WAIT;
            end
          end
        end
        S_RD_LEN: if (bus_ack_i) begin
          olen_q <= obuf_q ? clamp_len : '0;
          st_q   <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // Tracks whether the command word has reached the device in this command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cmd_wr_seen <= 1'b0;
    else if (st_q == S_IDLE && start_i)         cmd_wr_seen <= 1'b0;
    else if (st_q == S_WR_CMD && bus_ack_i)     cmd_wr_seen <= 1'b1;
  end

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b0;
    bus_addr_o  = A_CTRL;
    bus_wdata_o = '0;
    unique case (st_q)
      S_RD_CTRL, S_POLL_DB, S_RECHK: bus_addr_o = A_CTRL;
      S_WR_CMD: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = A_CMD;
        bus_wdata_o = DATA_W'(opc_q) | (DATA_W'(len_q) << LEN_LSB);
      end
      S_WR_DB: begin
        bus_we_o    = 1'b1;
        bus_addr_o  = A_CTRL;
        bus_wdata_o = DATA_W'(1) << DB_BIT;
      end
      S_RD_STAT: bus_addr_o = A_STAT;
      S_BG_RD:   bus_addr_o = A_BG;
      S_RD_LEN:  bus_addr_o = A_CMD;
      default:   bus_req_o  = 1'b0;
    endcase
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_DONE);
  assign err_o     = err_q;
  assign rc_o      = rc_q;
  assign out_len_o = olen_q;

  // R4
  db_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_addr_o == A_CTRL) |-> cmd_wr_seen);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  // R2
  busy_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == E_BUSY) |-> !cmd_wr_seen);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  olen_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_len_o <= cap_q && out_len_o <= psz_q));

  // R1
  inval_nobus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == E_INVAL) |-> $past(st_q == S_IDLE));
endmodule

// File: tb/sim_mbx_req_seq.sv
module sim_mbx_req_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DB_TMO     = 20;
  localparam int NEVER      = 1000000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [20:0] in_len_i = '0;
  logic        in_buf_i = 1'b0;
  logic [20:0] out_cap_i = '0;
  logic        out_buf_i = 1'b0;
  logic [20:0] pld_size_i = '0;
  logic        long_pend_i = 1'b0;
  logic [7:0]  poll_cnt_i = '0;
  logic [15:0] poll_ivl_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  err_o;
  logic [15:0] rc_o;
  logic [20:0] out_len_o;
  logic        bus_req_o, bus_we_o;
  logic [7:0]  bus_addr_o;
  logic [63:0] bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [63:0] bus_rdata_i = '0;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  // device model state
  logic        db = 1'b0;
  int          ctrl_rd = 0, clr_at = NEVER;
  int          n_wr = 0, n_rd = 0, n_cmd_wr = 0, n_db_wr = 0, n_bg_rd = 0, n_len_rd = 0, n_stat_rd = 0;
  bit          order_ok = 1;
  logic [63:0] cmd_seen = '0;
  logic [15:0] stat_rc = '0, bg_rc = '0;
  int          bg_done_at = 1;
  logic [20:0] rb_len = '0;

  // captured result
  logic [1:0]  r_err;
  logic [15:0] r_rc;
  logic [20:0] r_len;

  mbx_req_seq #(.DB_TMO(DB_TMO)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk_i) begin
    if (bus_ack_i) bus_ack_i = 1'b0;
    else if (bus_req_o) begin
      bus_rdata_i = '0;
      if (bus_we_o) begin
        n_wr++;
        if (bus_addr_o == 8'h08) begin n_cmd_wr++; cmd_seen = bus_wdata_o; end
        if (bus_addr_o == 8'h04 && bus_wdata_o[0]) begin
          n_db_wr++;
          if (n_cmd_wr == 0) order_ok = 0;
          db = 1'b1; ctrl_rd = 0;
        end
      end else begin
        n_rd++;
        case (bus_addr_o)
          8'h04: begin
            ctrl_rd++;
            if (ctrl_rd >= clr_at) db = 1'b0;
            bus_rdata_i = {63'b0, db};
          end
          8'h10: begin n_stat_rd++; bus_rdata_i = {16'b0, stat_rc, 32'b0}; end
          8'h18: begin
            n_bg_rd++;
            bus_rdata_i = {16'b0, bg_rc, 9'b0, (n_bg_rd >= bg_done_at) ? 7'd100 : 7'd40, opcode_i};
          end
          8'h08: begin n_len_rd++; bus_rdata_i = {27'b0, rb_len, 16'b0}; end
          default: bus_rdata_i = '0;
        endcase
      end
      bus_ack_i = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic model_clear();
    db = 0; ctrl_rd = 0; clr_at = NEVER;
    n_wr = 0; n_rd = 0; n_cmd_wr = 0; n_db_wr = 0; n_bg_rd = 0; n_len_rd = 0; n_stat_rd = 0;
    order_ok = 1; cmd_seen = '0; stat_rc = '0; bg_rc = '0; bg_done_at = 1; rb_len = '0;
    long_pend_i = 0; in_buf_i = 1; out_buf_i = 1; in_len_i = 0;
    out_cap_i = 21'd64; pld_size_i = 21'd256; poll_cnt_i = 8'd4; poll_ivl_i = 16'd3;
    opcode_i = 16'h0100;
  endtask

  task automatic run_cmd();
    int guard = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!done_o && guard < 5000) begin @(negedge clk_i); guard++; end
    r_err = err_o; r_rc = rc_o; r_len = out_len_o;
    chk(done_o == 1'b1, "R10 done seen", done_o, 1);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk_eq("R11 busy", busy_o, 0);
    chk_eq("R11 done", done_o, 0);
    chk_eq("R11 req", bus_req_o, 0);
    chk_eq("R11 err", err_o, 0);
  endtask

  task automatic t_inval();
    model_clear(); in_len_i = 21'd8; in_buf_i = 0;
    run_cmd();
    chk_eq("R1 err", r_err, 3);
    chk_eq("R1 bus accesses", n_wr + n_rd, 0);
  endtask

  task automatic t_db_busy();
    model_clear(); db = 1;
    run_cmd();
    chk_eq("R2 err", r_err, 1);
    chk_eq("R2 writes", n_wr, 0);
    chk_eq("R2 ctrl reads", ctrl_rd, 1);
  endtask

  task automatic t_gate();
    model_clear(); long_pend_i = 1; opcode_i = 16'h4400; clr_at = 2;
    run_cmd();
    chk_eq("R3 gated err", r_err, 1);
    chk_eq("R3 gated writes", n_wr, 0);
    model_clear(); long_pend_i = 1; opcode_i = 16'h4200; clr_at = 2; rb_len = 21'd20;
    run_cmd();
    chk_eq("R3 health err", r_err, 0);
    chk_eq("R3 health len", r_len, 20);
  endtask

  task automatic t_basic();
    model_clear(); opcode_i = 16'h0123; in_len_i = 21'd12; clr_at = 3; rb_len = 21'd40;
    run_cmd();
    chk_eq("R4 opcode field", cmd_seen[15:0], 16'h0123);
    chk_eq("R4 length field", cmd_seen[36:16], 12);
    chk_eq("R4 order", order_ok, 1);
    chk_eq("R4 doorbell writes", n_db_wr, 1);
    chk_eq("R9 out len", r_len, 40);
    chk_eq("R6 rc", r_rc, 0);
    chk_eq("R10 done low after", done_o, 0);
    repeat (3) @(negedge clk_i);
    chk_eq("R10 len held", out_len_o, 40);
    model_clear(); in_len_i = 0; in_buf_i = 0; opcode_i = 16'h0400; clr_at = 1;
    run_cmd();
    chk_eq("R4 zero length field", cmd_seen[36:16], 0);
    chk_eq("R4 zero-len err", r_err, 0);
  endtask

  task automatic t_rc_err();
    model_clear(); stat_rc = 16'h0005; clr_at = 2; rb_len = 21'd30;
    run_cmd();
    chk_eq("R6 err", r_err, 0);
    chk_eq("R6 rc", r_rc, 5);
    chk_eq("R6 len", r_len, 0);
    chk_eq("R6 no len read", n_len_rd, 0);
  endtask

  task automatic t_db_tmo();
    int n_tmo;
    model_clear(); rb_len = 21'd10;
    run_cmd();
    chk_eq("R5 timeout err", r_err, 2);
    chk_eq("R5 no status read", n_stat_rd, 0);
    n_tmo = ctrl_rd;
    chk(n_tmo >= 2, "R5 polls before timeout", n_tmo, 2);
    model_clear(); rb_len = 21'd10; clr_at = n_tmo;
    run_cmd();
    chk_eq("R5 recheck rescues err", r_err, 0);
    chk_eq("R5 recheck rescues len", r_len, 10);
    chk_eq("R5 recheck read count", ctrl_rd, n_tmo);
  endtask

  task automatic t_bg();
    model_clear(); stat_rc = 16'h0001; clr_at = 2; bg_done_at = 3; poll_cnt_i = 5;
    bg_rc = 16'h0000; rb_len = 21'd33;
    run_cmd();
    chk_eq("R7 bg err", r_err, 0);
    chk_eq("R7 bg reads", n_bg_rd, 3);
    chk_eq("R7 bg len", r_len, 33);
    model_clear(); stat_rc = 16'h0001; clr_at = 2; bg_done_at = 2; poll_cnt_i = 5;
    bg_rc = 16'h0007; rb_len = 21'd33;
    run_cmd();
    chk_eq("R8 bg rc", r_rc, 7);
    chk_eq("R8 bg len", r_len, 0);
    chk_eq("R8 no len read", n_len_rd, 0);
    model_clear(); stat_rc = 16'h0001; clr_at = 2; bg_done_at = NEVER; poll_cnt_i = 4;
    run_cmd();
    chk_eq("R7 bg timeout err", r_err, 2);
    chk_eq("R7 bg timeout reads", n_bg_rd, 4);
    model_clear(); stat_rc = 16'h0001; clr_at = 2; bg_done_at = NEVER; poll_cnt_i = 0;
    run_cmd();
    chk_eq("R7 zero count err", r_err, 2);
    chk_eq("R7 zero count reads", n_bg_rd, 1);
  endtask

  task automatic t_clamp();
    model_clear(); clr_at = 1; out_cap_i = 21'd16; pld_size_i = 21'd256; rb_len = 21'd40;
    run_cmd(); chk_eq("R9 cap smallest", r_len, 16);
    model_clear(); clr_at = 1; out_cap_i = 21'd64; pld_size_i = 21'd8; rb_len = 21'd40;
    run_cmd(); chk_eq("R9 payload smallest", r_len, 8);
    model_clear(); clr_at = 1; out_buf_i = 0; rb_len = 21'd40;
    run_cmd(); chk_eq("R9 no buffer", r_len, 0);
    model_clear(); clr_at = 1; rb_len = 21'd0;
    run_cmd(); chk_eq("R9 zero readback", r_len, 0);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_inval();
    t_db_busy();
    t_gate();
    t_basic();
    t_rc_err();
    t_db_tmo();
    t_bg();
    t_clamp();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule